// File: doc/BRIEF.md
# DSD Bitstream Input Receiver

This block receives two one-bit Direct Stream Digital channels that share a single bit clock and turns them into decoded bit streams in the system clock domain. The bit clock and both data lines are brought into the system clock domain through the same synchronizer depth. Each rising edge of the bit clock is found there by edge detection, and the data is taken at that edge. A decoded bit for both channels leaves the block together with a one-cycle valid strobe.

A mode input selects one of three ways of reading the lines: plain sampling at 64x, plain sampling at 128x, or phase-modulated decoding. In the phase-modulated mode one data bit covers two bit-clock periods and is read from the pair of samples taken at those two edges. A pair that is neither the reference shape nor its inverse raises a per-channel phase-error pulse.

Each channel also watches for the silence byte 0x69. It declares mute after a configurable run of matching bytes and drops mute on the first byte that does not match. Writing a new value on the mode input resynchronizes the decoder.

Top module: `dsd_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bitA, bitB, bitValid, muteA, muteB, phaseErrA and phaseErrB are all 0.
- R2: In the normal modes (mode 2'b00 for 64x, 2'b01 for 128x, and the spare code 2'b11, which behaves the same), each rising edge of dsdClk yields exactly one bitValid pulse. bitA and bitB then carry the levels of dsdA and dsdB at that edge, each channel independently.
- R3: In phase-modulated mode (mode 2'b10), a bit spans two consecutive rising edges of dsdClk and gives one bitValid pulse after the second edge. Samples (1,0) decode to 1 and samples (0,1) decode to 0.
- R4: In phase-modulated mode, a pair whose two samples are equal makes that channel's phaseErr output pulse high in the same cycle as bitValid. The decoded bit is then the first sample.
- R5: Decoded bits form bytes, most significant bit first, counted from reset or from the last resynchronization. A channel's mute output rises in the bitValid cycle that completes the MUTE_BYTES-th consecutive byte equal to 8'h69 (default MUTE_BYTES = 4). It stays high while further bytes match.
- R6: A muted channel clears its mute output in the bitValid cycle that completes the first byte other than 8'h69.
- R7: Each channel keeps its own byte match count and mute state. Silence on one channel never mutes the other.
- R8: A change of the mode input clears both mute outputs and both match counts within one cycle. It also restarts byte alignment and, in phase-modulated mode, the pairing of the two edges.
- R9: phaseErrA and phaseErrB stay low outside phase-modulated mode, and bitValid never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be well above the bit clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 normal 64x, 01 normal 128x, 10 phase-modulated, 11 normal |
| dsdClk | input | 1 | Shared DSD bit clock (asynchronous) |
| dsdA | input | 1 | Channel A data line |
| dsdB | input | 1 | Channel B data line |
| bitA | output | 1 | Decoded channel A bit, valid with bitValid |
| bitB | output | 1 | Decoded channel B bit, valid with bitValid |
| bitValid | output | 1 | One-cycle strobe per decoded bit |
| muteA | output | 1 | Channel A silence-pattern mute |
| muteB | output | 1 | Channel B silence-pattern mute |
| phaseErrA | output | 1 | Channel A phase-modulation pair error pulse |
| phaseErrB | output | 1 | Channel B phase-modulation pair error pulse |

## Verification
The assertions assume three things about the inputs. The mode input is driven synchronously to clk. The bit clock is slow enough that each of its high and low phases lasts at least one system cycle. The data lines change away from the rising edge of the bit clock. The stimulus meets these conditions by holding each half of the bit clock for four system cycles and changing data only while the bit clock is low. It changes mode only when the bit clock is idle. Under these conditions the bench can predict every decoded bit, error flag and mute level from a plain byte-level model of the requirements.

// File: rtl/dsd_rx_pkg.sv
package dsd_rx_pkg;

  typedef enum logic [1:0] {
    MODE_N64  = 2'b00,
    MODE_N128 = 2'b01,
    MODE_PM   = 2'b10,
    MODE_SPARE = 2'b11
  } rxMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic resync;     // mode changed: clear alignment and mute state
    logic sample;     // rising bit-clock edge seen this cycle
    logic firstHalf;  // this edge is the first of a phase-modulated pair
    logic emit;       // a decoded bit is complete this cycle
    logic byteDone;   // the emitted bit completes a byte
    logic pm;         // phase-modulated decoding is active
  } rxStrobe_t;

endpackage

// File: rtl/dsd_rx_sync.sv
module dsd_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/dsd_rx_ctrl.sv
module dsd_rx_ctrl
  import dsd_rx_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       clkSync,
  output rxStrobe_t  strb
);

  localparam int CW = $clog2(BYTE_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_BITS - 1);

  logic          clkPrev;
  logic [1:0]    modePrev;
  logic          halfPhase;
  logic [CW-1:0] bitCnt;
  logic          rise, resync, pm, emit;

  assign pm     = (mode == MODE_PM);
  assign rise   = clkSync & ~clkPrev;
  assign resync = (mode != modePrev);
  assign emit   = rise & ~resync & (~pm | halfPhase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b0;
      modePrev  <= MODE_N64;
      halfPhase <= 1'b0;
      bitCnt    <= '0;
    end else begin
      clkPrev  <= clkSync;
      modePrev <= mode;
      if (resync) begin
        halfPhase <= 1'b0;
        bitCnt    <= '0;
      end else begin
        if (!pm)       halfPhase <= 1'b0;
        else if (rise) halfPhase <= ~halfPhase;
        if (emit) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  assign strb.resync    = resync;
  assign strb.sample    = rise & ~resync;
  assign strb.firstHalf = pm & ~halfPhase;
  assign strb.emit      = emit;
  assign strb.byteDone  = emit & (bitCnt == LAST_BIT);
  assign strb.pm        = pm;

endmodule

// File: rtl/dsd_rx_datapath.sv
module dsd_rx_datapath
  import dsd_rx_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int BYTE_BITS  = 8,
  parameter int MUTE_BYTES = 4,
  parameter logic [BYTE_BITS-1:0] PATTERN = 8'h69
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [NUM_CH-1:0] dataSync,
  output logic [NUM_CH-1:0] bitOut,
  output logic [NUM_CH-1:0] errOut,
  output logic [NUM_CH-1:0] muteOut,
  output logic              validOut
);

  localparam int MW = $clog2(MUTE_BYTES + 1);
  localparam logic [MW-1:0] CNT_MAX  = MW'(MUTE_BYTES);
  localparam logic [MW-1:0] CNT_TRIP = MW'(MUTE_BYTES - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= strb.emit;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic                 firstSmp;
    logic [BYTE_BITS-2:0] shiftQ;
    logic [MW-1:0]        matchCnt;
    logic                 bitQ, errQ, muteQ;
    logic                 decBit, decErr;
    logic [BYTE_BITS-1:0] byteNow;

    // in phase-modulated mode the first sample carries the bit
    assign decBit  = strb.pm ? firstSmp : dataSync[ch];
    assign decErr  = strb.pm & (firstSmp == dataSync[ch]);
    assign byteNow = {shiftQ, decBit};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        firstSmp <= 1'b0;
        shiftQ   <= '0;
        matchCnt <= '0;
        bitQ     <= 1'b0;
        errQ     <= 1'b0;
        muteQ    <= 1'b0;
      end else if (strb.resync) begin
        firstSmp <= 1'b0;
        shiftQ   <= '0;
        matchCnt <= '0;
        bitQ     <= 1'b0;
        errQ     <= 1'b0;
        muteQ    <= 1'b0;
      end else begin
        if (strb.sample && strb.firstHalf) firstSmp <= dataSync[ch];
        errQ <= strb.emit & decErr;
        if (strb.emit) begin
          bitQ   <= decBit;
          shiftQ <= byteNow[BYTE_BITS-2:0];
        end
        if (strb.byteDone) begin
          if (byteNow == PATTERN) begin
            if (matchCnt != CNT_MAX) matchCnt <= matchCnt + 1'b1;
            if (matchCnt >= CNT_TRIP) muteQ <= 1'b1;
          end else begin
            matchCnt <= '0;
            muteQ    <= 1'b0;
          end
        end
      end
    end

    assign bitOut[ch]  = bitQ;
    assign errOut[ch]  = errQ;
    assign muteOut[ch] = muteQ;
  end

endmodule

// File: rtl/dsd_rx.sv
module dsd_rx
  import dsd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8,
  parameter int MUTE_BYTES  = 4,
  parameter logic [7:0] PATTERN = 8'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       dsdClk,
  input  logic       dsdA,
  input  logic       dsdB,
  output logic       bitA,
  output logic       bitB,
  output logic       bitValid,
  output logic       muteA,
  output logic       muteB,
  output logic       phaseErrA,
  output logic       phaseErrB
);

  localparam int NUM_CH = 2;

  logic [NUM_CH:0]   syncOut;
  logic [NUM_CH-1:0] bitOut, errOut, muteOut;
  rxStrobe_t         strb;

  dsd_rx_sync #(.WIDTH(NUM_CH + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({dsdB, dsdA, dsdClk}),
    .dout(syncOut)
  );

  dsd_rx_ctrl #(.BYTE_BITS(BYTE_BITS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .mode   (mode),
    .clkSync(syncOut[0]),
    .strb   (strb)
  );

  dsd_rx_datapath #(
    .NUM_CH    (NUM_CH),
    .BYTE_BITS (BYTE_BITS),
    .MUTE_BYTES(MUTE_BYTES),
    .PATTERN   (BYTE_BITS'(PATTERN))
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataSync(syncOut[NUM_CH:1]),
    .bitOut  (bitOut),
    .errOut  (errOut),
    .muteOut (muteOut),
    .validOut(bitValid)
  );

  assign bitA      = bitOut[0];
  assign bitB      = bitOut[1];
  assign muteA     = muteOut[0];
  assign muteB     = muteOut[1];
  assign phaseErrA = errOut[0];
  assign phaseErrB = errOut[1];

endmodule

// File: rtl/dsd_rx_checker.sv
module dsd_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       bitValid,
  input logic       muteA,
  input logic       muteB,
  input logic       phaseErrA,
  input logic       phaseErrB
);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  p_err_with_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phaseErrA || phaseErrB) |-> bitValid);

  p_err_only_pm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phaseErrA || phaseErrB) |-> ($past(mode) == 2'b10));

  p_mute_rise_on_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(muteA) || $rose(muteB)) |-> bitValid);

  p_mode_change_unmute_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |=> (!muteA && !muteB));

endmodule

bind dsd_rx dsd_rx_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .bitValid (bitValid),
  .muteA    (muteA),
  .muteB    (muteB),
  .phaseErrA(phaseErrA),
  .phaseErrB(phaseErrB)
);

// File: tb/sim_dsd_rx.sv
`timescale 1ns/1ps
module sim_dsd_rx;

  localparam int DEPTH = 8192;
  localparam int MUTE_N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'b00;
  logic dsdClk = 1'b0, dsdA = 1'b0, dsdB = 1'b0;
  logic bitA, bitB, bitValid, muteA, muteB, phaseErrA, phaseErrB;

  always #10 clk = ~clk;

  dsd_rx u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .dsdClk(dsdClk), .dsdA(dsdA), .dsdB(dsdB),
    .bitA(bitA), .bitB(bitB), .bitValid(bitValid), .muteA(muteA), .muteB(muteB),
    .phaseErrA(phaseErrA), .phaseErrB(phaseErrB)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // expected stream
  logic expA [DEPTH], expB [DEPTH], expEA [DEPTH], expEB [DEPTH];
  logic expMA [DEPTH], expMB [DEPTH], expPm [DEPTH];
  int nExp = 0;
  // observed stream
  logic obsA [DEPTH], obsB [DEPTH], obsEA [DEPTH], obsEB [DEPTH];
  logic obsMA [DEPTH], obsMB [DEPTH];
  int nObs = 0;

  // requirement model state
  int mIdx = 0, mCntA = 0, mCntB = 0;
  logic [7:0] mByteA = '0, mByteB = '0;
  logic mMuteA = 0, mMuteB = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mIdx = 0; mCntA = 0; mCntB = 0; mByteA = '0; mByteB = '0; mMuteA = 0; mMuteB = 0;
  endtask

  task automatic modelBit(input logic a, input logic b, input logic ea, input logic eb);
    mByteA = {mByteA[6:0], a};
    mByteB = {mByteB[6:0], b};
    mIdx++;
    if (mIdx == 8) begin
      mIdx = 0;
      if (mByteA == 8'h69) begin mCntA++; if (mCntA >= MUTE_N) mMuteA = 1; end
      else begin mCntA = 0; mMuteA = 0; end
      if (mByteB == 8'h69) begin mCntB++; if (mCntB >= MUTE_N) mMuteB = 1; end
      else begin mCntB = 0; mMuteB = 0; end
    end
    if (nExp < DEPTH) begin
      expA[nExp] = a; expB[nExp] = b; expEA[nExp] = ea; expEB[nExp] = eb;
      expMA[nExp] = mMuteA; expMB[nExp] = mMuteB; expPm[nExp] = (mode == 2'b10);
      nExp++;
    end
  endtask

  always @(negedge clk) begin
    if (rstN && bitValid && nObs < DEPTH) begin
      obsA[nObs] = bitA; obsB[nObs] = bitB; obsEA[nObs] = phaseErrA; obsEB[nObs] = phaseErrB;
      obsMA[nObs] = muteA; obsMB[nObs] = muteB;
      nObs++;
    end
  end

  task automatic dsdPeriod(input logic a, input logic b);
    dsdA = a; dsdB = b;
    repeat (4) @(negedge clk);
    dsdClk = 1'b1;
    repeat (4) @(negedge clk);
    dsdClk = 1'b0;
  endtask

  task automatic normByte(input logic [7:0] va, input logic [7:0] vb);
    for (int i = 7; i >= 0; i--) begin
      dsdPeriod(va[i], vb[i]);
      modelBit(va[i], vb[i], 1'b0, 1'b0);
    end
  endtask

  task automatic pmByte(input logic [7:0] va, input logic [7:0] vb, input logic [7:0] errB);
    for (int i = 7; i >= 0; i--) begin
      logic b1;
      b1 = errB[i] ? vb[i] : ~vb[i];
      dsdPeriod(va[i], vb[i]);
      dsdPeriod(~va[i], b1);
      modelBit(va[i], vb[i], 1'b0, vb[i] == b1);
    end
  endtask

  task automatic setMode(input logic [1:0] m);
    mode = m;
    repeat (3) @(negedge clk);
    modelReset();
    check(muteA == 0 && muteB == 0, "R8 mute cleared on mode change", int'({muteA, muteB}), 0);
  endtask

  task automatic checkLive(input string tag);
    check(muteA == mMuteA, {tag, " muteA"}, int'(muteA), int'(mMuteA));
    check(muteB == mMuteB, {tag, " muteB"}, int'(muteB), int'(mMuteB));
  endtask

  initial begin
    repeat (1000 * 190) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check({bitA, bitB, bitValid, muteA, muteB, phaseErrA, phaseErrB} == 7'd0,
          "R1 reset outputs", int'({bitA, bitB, bitValid, muteA, muteB, phaseErrA, phaseErrB}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({bitValid, muteA, muteB, phaseErrA, phaseErrB} == 5'd0, "R1 after release",
          int'({bitValid, muteA, muteB, phaseErrA, phaseErrB}), 0);

    // R2: every byte value on both channels in 64x normal mode
    for (int v = 0; v < 256; v++) normByte(8'(v), 8'(255 - v));
    // R5 / R7: silence on A, B partially
    for (int k = 0; k < 3; k++) normByte(8'h69, 8'h69);
    checkLive("R5 not yet muted");
    normByte(8'h69, 8'h00);
    checkLive("R5 R7 A muted B not");
    check(muteA == 1'b1, "R5 muteA after four bytes", int'(muteA), 1);
    check(muteB == 1'b0, "R7 muteB independent", int'(muteB), 0);
    normByte(8'h69, 8'h69);
    checkLive("R5 hold");
    normByte(8'h68, 8'h69);
    check(muteA == 1'b0, "R6 muteA cleared", int'(muteA), 0);
    for (int k = 0; k < 4; k++) normByte(8'h69, 8'h69);
    checkLive("R5 both muted");

    // R8: mode change clears mute and restarts alignment
    setMode(2'b01);
    for (int k = 0; k < 3; k++) begin
      dsdPeriod(1'b1, 1'b0);
      modelBit(1'b1, 1'b0, 1'b0, 1'b0);
    end
    setMode(2'b11);
    for (int k = 0; k < 4; k++) normByte(8'h69, 8'h69);
    checkLive("R8 realigned bytes mute");
    check(muteA == 1'b1, "R8 alignment restart", int'(muteA), 1);

    // R3 / R4: phase-modulated sweep with injected errors on B
    setMode(2'b10);
    for (int v = 0; v < 256; v++) pmByte(8'(v), 8'(~v), 8'(v * 37));
    for (int k = 0; k < 4; k++) pmByte(8'h69, 8'h69, 8'h00);
    checkLive("R5 pm mute");
    // half pair then resync: pairing must restart
    dsdPeriod(1'b1, 1'b1);
    setMode(2'b00);
    setMode(2'b10);
    pmByte(8'hA5, 8'h5A, 8'h00);
    pmByte(8'h3C, 8'hC3, 8'hFF);
    repeat (4) @(negedge clk);

    check(nObs == nExp, "R2 R3 bitValid count", nObs, nExp);
    for (int k = 0; k < nExp && k < nObs; k++) begin
      check(obsA[k] == expA[k], expPm[k] ? "R3 bitA" : "R2 bitA", int'(obsA[k]), int'(expA[k]));
      check(obsB[k] == expB[k], expPm[k] ? "R3 bitB" : "R2 bitB", int'(obsB[k]), int'(expB[k]));
      check(obsEA[k] == expEA[k], expPm[k] ? "R4 phaseErrA" : "R9 phaseErrA", int'(obsEA[k]), int'(expEA[k]));
      check(obsEB[k] == expEB[k], expPm[k] ? "R4 phaseErrB" : "R9 phaseErrB", int'(obsEB[k]), int'(expEB[k]));
      check(obsMA[k] == expMA[k], "R5 R6 muteA", int'(obsMA[k]), int'(expMA[k]));
      check(obsMB[k] == expMB[k], "R5 R7 muteB", int'(obsMB[k]), int'(expMB[k]));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule